// File: doc/BRIEF.md
# Main and ALU Control Decoder

This block is the purely combinational control unit of a single-cycle RISC core. It takes the 32-bit instruction word and returns every steering signal the datapath needs: where the register write address comes from, whether the second ALU operand is the immediate, whether the write-back value comes from data memory, the register-file and data-memory enables, the branch and jump flags, a coarse 2-bit ALU class and the final 4-bit ALU operation select.

Decoding happens in two steps. The opcode alone yields a coarse ALU class. Only for register-format instructions is that class refined by the function field into a concrete operation. The supported set is load word, store word, branch-if-equal, jump, and the register-format add, sub, and, or and set-less-than. Any other opcode, or a register-format word with an unknown function code, produces a control word with every enable and flag inactive, so the datapath's architectural state stays untouched.

Top module: `ctl_decoder`

## Requirements
- R1: Only the opcode (instruction bits 31..26) and the function field (bits 5..0) affect the outputs; bits 25..6 have no effect.
- R2: Opcode 000000 with a supported function code drives reg_dst=1, reg_wr=1, alu_op=10, and alu_src, mem_to_reg, mem_rd, mem_wr, branch and jump all 0.
- R3: For opcode 000000, the function codes 100000, 100010, 100100, 100101 and 101010 give alu_sel 0010 (add), 0110 (sub), 0000 (and), 0001 (or) and 0111 (set-less-than).
- R4: Opcode 100011 (load) drives alu_src=1, mem_rd=1, mem_to_reg=1, reg_wr=1, reg_dst=0, mem_wr=0, branch=0, jump=0, alu_op=00, alu_sel=0010.
- R5: Opcode 101011 (store) drives alu_src=1, mem_wr=1, reg_wr=0, and reg_dst, mem_to_reg, mem_rd, branch, jump all 0, alu_op=00, alu_sel=0010.
- R6: Opcode 000100 (branch-if-equal) drives branch=1, alu_op=01, alu_sel=0110, and every other single-bit control 0.
- R7: Opcode 000010 (jump) drives jump=1, alu_op=00, alu_sel=0010, and every other single-bit control 0.
- R8: Any other opcode drives all eight single-bit controls to 0, alu_op=00 and alu_sel=0010.
- R9: Opcode 000000 with any unsupported function code drives all eight single-bit controls to 0, alu_op=10 and alu_sel=0000.
- R10: At most one of reg_wr, mem_wr, branch and jump is 1 for any instruction; mem_rd and mem_wr are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Fetched instruction word |
| reg_dst | output | 1 | 1: write address from bits 15..11, 0: from bits 20..16 |
| alu_src | output | 1 | 1: second ALU operand is the sign-extended immediate |
| mem_to_reg | output | 1 | 1: write-back value is data-memory read data |
| reg_wr | output | 1 | Register-file write enable |
| mem_rd | output | 1 | Data-memory read enable |
| mem_wr | output | 1 | Data-memory write enable |
| branch | output | 1 | Conditional branch on ALU zero |
| jump | output | 1 | Unconditional jump |
| alu_op | output | 2 | Coarse ALU class: 00 add, 01 subtract, 10 from function field |
| alu_sel | output | 4 | Final ALU operation select |

## Verification
The block holds no state, so every fault appears at the ports in the same evaluation as the instruction that exposes it; there is no latency to wait for. A wrong entry in the opcode table shows as a mismatched control word for that one opcode only, which is why every supported opcode is applied directly and random opcodes cover the rest. A broken function-field refinement shows only on register-format words, either as a wrong alu_sel or as a register write left enabled for an unknown function code. Random fill of bits 25..6 exposes any decode that looks at the wrong field.

// File: rtl/ctl_decoder.sv
module ctl_decoder (
  input  logic [31:0] instr,
  output logic        reg_dst,
  output logic        alu_src,
  output logic        mem_to_reg,
  output logic        reg_wr,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic        branch,
  output logic        jump,
  output logic [1:0]  alu_op,
  output logic [3:0]  alu_sel
);

  localparam logic [5:0] OP_REG   = 6'b000000;
  localparam logic [5:0] OP_LOAD  = 6'b100011;
  localparam logic [5:0] OP_STORE = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_JMP   = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  localparam logic [1:0] CLS_ADD = 2'b00;
  localparam logic [1:0] CLS_SUB = 2'b01;
  localparam logic [1:0] CLS_FN  = 2'b10;

  localparam logic [3:0] SEL_AND = 4'b0000;
  localparam logic [3:0] SEL_OR  = 4'b0001;
  localparam logic [3:0] SEL_ADD = 4'b0010;
  localparam logic [3:0] SEL_SUB = 4'b0110;
  localparam logic [3:0] SEL_SLT = 4'b0111;

  logic [5:0] opcode;
  logic [5:0] funct;
  logic       funct_ok;

  assign opcode = instr[31:26];
  assign funct  = instr[5:0];

  assign funct_ok = (funct == FN_ADD) || (funct == FN_SUB) || (funct == FN_AND) ||
                    (funct == FN_OR)  || (funct == FN_SLT);

  always_comb begin
    reg_dst    = 1'b0;
    alu_src    = 1'b0;
    mem_to_reg = 1'b0;
    reg_wr     = 1'b0;
    mem_rd     = 1'b0;
    mem_wr     = 1'b0;
    branch     = 1'b0;
    jump       = 1'b0;
    alu_op     = CLS_ADD;
    case (opcode)
      OP_REG: begin
        alu_op  = CLS_FN;
        reg_dst = funct_ok;
        reg_wr  = funct_ok;
      end
      OP_LOAD: begin
        alu_src    = 1'b1;
        mem_rd     = 1'b1;
        mem_to_reg = 1'b1;
        reg_wr     = 1'b1;
      end
      OP_STORE: begin
        alu_src = 1'b1;
        mem_wr  = 1'b1;
      end
      OP_BEQ: begin
        branch = 1'b1;
        alu_op = CLS_SUB;
      end
      OP_JMP: jump = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    case (alu_op)
      CLS_ADD: alu_sel = SEL_ADD;
      CLS_SUB: alu_sel = SEL_SUB;
      CLS_FN: begin
        case (funct)
          FN_ADD:  alu_sel = SEL_ADD;
          FN_SUB:  alu_sel = SEL_SUB;
          FN_AND:  alu_sel = SEL_AND;
          FN_OR:   alu_sel = SEL_OR;
          FN_SLT:  alu_sel = SEL_SLT;
          default: alu_sel = SEL_AND;
        endcase
      end
      default: alu_sel = SEL_AND;
    endcase
  end

  always_comb begin
    p_single_effect_r10: assert ($onehot0({reg_wr, mem_wr, branch, jump}))
      else $error("reg_wr/mem_wr/branch/jump not exclusive");
    p_mem_excl_r10: assert (!(mem_rd && mem_wr))
      else $error("memory read and write both enabled");
    p_load_path_r4: assert (!mem_to_reg || (mem_rd && reg_wr && alu_src))
      else $error("mem_to_reg without a complete load");
    p_imm_adds_r5: assert (!alu_src || (alu_op == CLS_ADD && alu_sel == SEL_ADD))
      else $error("immediate operand without an add");
    p_branch_sub_r6: assert (!branch || alu_sel == SEL_SUB)
      else $error("branch without subtract");
    p_regdst_fn_r2: assert (!reg_dst || (reg_wr && alu_op == CLS_FN))
      else $error("reg_dst outside a register-format write");
  end

endmodule

// File: tb/tb_ctl_decoder.sv
module tb_ctl_decoder;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [31:0] instr;
  logic reg_dst, alu_src, mem_to_reg, reg_wr, mem_rd, mem_wr, branch, jump;
  logic [1:0] alu_op;
  logic [3:0] alu_sel;

  ctl_decoder dut (
    .instr(instr), .reg_dst(reg_dst), .alu_src(alu_src), .mem_to_reg(mem_to_reg),
    .reg_wr(reg_wr), .mem_rd(mem_rd), .mem_wr(mem_wr), .branch(branch),
    .jump(jump), .alu_op(alu_op), .alu_sel(alu_sel)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // word: {reg_dst,alu_src,mem_to_reg,reg_wr,mem_rd,mem_wr,branch,jump,alu_op,alu_sel}
  function automatic logic [13:0] expect_word(input logic [31:0] w);
    logic [5:0] op = w[31:26];
    logic [5:0] fn = w[5:0];
    case (op)
      6'b000000: begin
        case (fn)
          6'b100000: return {8'b1001_0000, 2'b10, 4'b0010};
          6'b100010: return {8'b1001_0000, 2'b10, 4'b0110};
          6'b100100: return {8'b1001_0000, 2'b10, 4'b0000};
          6'b100101: return {8'b1001_0000, 2'b10, 4'b0001};
          6'b101010: return {8'b1001_0000, 2'b10, 4'b0111};
          default:   return {8'b0000_0000, 2'b10, 4'b0000};
        endcase
      end
      6'b100011: return {8'b0111_1000, 2'b00, 4'b0010};
      6'b101011: return {8'b0100_0100, 2'b00, 4'b0010};
      6'b000100: return {8'b0000_0010, 2'b01, 4'b0110};
      6'b000010: return {8'b0000_0001, 2'b00, 4'b0010};
      default:   return {8'b0000_0000, 2'b00, 4'b0010};
    endcase
  endfunction

  function automatic string req_of(input logic [31:0] w);
    logic [5:0] op = w[31:26];
    logic [5:0] fn = w[5:0];
    case (op)
      6'b000000:
        if (fn inside {6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b101010})
          return "R2/R3";
        else return "R9";
      6'b100011: return "R4";
      6'b101011: return "R5";
      6'b000100: return "R6";
      6'b000010: return "R7";
      default:   return "R8";
    endcase
  endfunction

  task automatic apply(input logic [31:0] w, input string tag);
    logic [13:0] got;
    logic [13:0] exp;
    @(negedge clk);
    instr = w;
    #1;
    got = {reg_dst, alu_src, mem_to_reg, reg_wr, mem_rd, mem_wr, branch, jump, alu_op, alu_sel};
    exp = expect_word(w);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s instr=%h actual=%b expected=%b", tag, w, got, exp);
    end
    checks++;
    if (!$onehot0({reg_wr, mem_wr, branch, jump}) || (mem_rd && mem_wr)) begin
      errors++;
      $display("FAIL R10 instr=%h actual=%b expected=exclusive enables", w, got);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [19:0] mid,
                                     input logic [5:0] fn);
    return {op, mid, fn};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [5:0] ops [6] = '{6'b000000, 6'b100011, 6'b101011, 6'b000100, 6'b000010, 6'b000000};
    logic [5:0] fns [5] = '{6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b101010};
    void'($urandom(32'd20240));
    instr = '0;

    // all-zero word: register format with unknown function code
    apply(32'h0000_0000, "R9");
    // directed register-format operations
    apply(mk(6'b000000, 20'h0A5C3, 6'b100000), "R2/R3 add");
    apply(mk(6'b000000, 20'h12345, 6'b100010), "R2/R3 sub");
    apply(mk(6'b000000, 20'hFFFFF, 6'b100100), "R2/R3 and");
    apply(mk(6'b000000, 20'h00001, 6'b100101), "R2/R3 or");
    apply(mk(6'b000000, 20'h80000, 6'b101010), "R2/R3 slt");
    apply(mk(6'b000000, 20'h00000, 6'b111111), "R9");
    apply(mk(6'b000000, 20'h00000, 6'b100001), "R9");
    apply(mk(6'b100011, 20'h00000, 6'b000000), "R4");
    apply(mk(6'b101011, 20'h54321, 6'b100000), "R5");
    apply(mk(6'b000100, 20'hABCDE, 6'b100100), "R6");
    apply(mk(6'b000010, 20'h00FF0, 6'b101010), "R7");
    apply(mk(6'b111111, 20'h00000, 6'b100000), "R8");
    apply(mk(6'b100010, 20'h00000, 6'b000000), "R8");
    apply(mk(6'b000011, 20'h00000, 6'b000000), "R8");
    // middle bits must not matter
    apply(mk(6'b100011, 20'hFFFFF, 6'b111111), "R1 load");
    apply(mk(6'b000000, 20'hFFFFF, 6'b100101), "R1 or");
    apply(mk(6'b101011, 20'hFFFFF, 6'b000000), "R1 store");

    for (int i = 0; i < 3000; i++) begin
      logic [5:0] op;
      logic [5:0] fn;
      logic [19:0] mid;
      mid = 20'($urandom);
      op = ($urandom % 3 == 0) ? 6'($urandom) : ops[$urandom % 6];
      fn = ($urandom % 4 == 0) ? 6'($urandom) : fns[$urandom % 5];
      apply(mk(op, mid, fn), {"R1 ", req_of(mk(op, mid, fn))});
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule